// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block merges 64 level-sensitive peripheral interrupt lines and 8 level-sensitive core-local lines onto two outputs for a processor core. The normal interrupt output is raised whenever any line is both active and unmasked. The fast interrupt output follows the raw level of one line, picked by a 7-bit index that spans both banks. That output ignores the masks altogether.

Software controls the block through a synchronous 32-bit register port that takes word accesses only. Masks are changed without read-modify-write: bits written to one address are set in a mask, and bits written to a companion address are cleared from it. A summary register gives a one-read view of the pending state. It shows the core-local lines, one flag per peripheral half and copies of a fixed group of peripheral lines. Pending state is never latched; it follows the input levels. Synchronising the inputs is left to the integrator.

Top module: `lvl_irq_agg`

## Requirements
- R1: After reset all masks are zero, the fast-interrupt enable and source index are zero, both interrupt outputs are low and `rd_data` is zero.
- R2: A write to byte offset 0x10, 0x14 or 0x18 ORs the written data into the mask of peripheral lines 31..0, peripheral lines 63..32, or core lines 7..0 (data bits 7:0) respectively; a read of the same offset returns that mask, with core mask bits 31:8 reading zero.
- R3: A write to byte offset 0x1C, 0x20 or 0x24 clears the written 1-bits from the peripheral-low, peripheral-high or core mask respectively, leaving other bits unchanged.
- R4: A read of offset 0x1C, 0x20 or 0x24 returns the bitwise inverse of the matching mask, zero-extended to 32 bits before inversion.
- R5: A read of offset 0x04 returns the levels of peripheral lines 31..0 ANDed with their mask; offset 0x08 does the same for lines 63..32.
- R6: A read of offset 0x00 returns the masked core lines in bits 7:0, bit 8 set when any masked-in line 31..0 is high, and bit 9 for lines 63..32. Bits 20..10 give the masked state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62, with line 7 in bit 10 and line 62 in bit 20. Bits 31:21 read zero.
- R7: A write to offset 0x0C loads the fast-interrupt source index from data bits 6:0 and its enable from bit 7; a read returns them in the same bits, with bits 31:8 zero.
- R8: With the fast interrupt enabled, `fiq` equals the raw level of peripheral line `index` for indices 0..63 and of core line `index-64` for 64..71, whatever the masks hold. It is low for indices 72..127, and low whenever the enable is clear.
- R9: `irq` is high exactly when some peripheral or core line is high and its mask bit is set.
- R10: `irq` and `fiq` are registered: an input level or register write present at a clock edge is shown on them right after that edge. `rd_data` is loaded at the edge that samples a read request and holds until the next read.
- R11: A read of any other offset, including one not word-aligned, returns zero. A write to such an offset or to 0x00, 0x04 or 0x08 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_lvl | input | 64 | Peripheral interrupt levels |
| core_lvl | input | 8 | Core-local interrupt levels |
| req_valid | input | 1 | Register access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Masked aggregate interrupt |
| fiq | output | 1 | Fast interrupt from the selected line |

## Verification
The masks are first built and removed one bit group at a time. This tells the OR and AND-NOT update rules apart from a plain overwrite, and the inverted readback from the direct one. Random level patterns on both banks then run against random masks, so every pending view and the aggregate output are compared with a model across many mixes of masked and unmasked lines. Single lines on the mirrored list and next to it show whether each copy bit is wired to the right line. The fast-interrupt index is stepped through the peripheral range, the core range and the dead range above 71, with the masks cleared. This shows that the output follows raw levels and that the index is not decoded modulo the bank size.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int PERIPH_N = 64;
    localparam int CORE_N   = 8;
    localparam int DATA_W   = 32;
    localparam int SEL_W    = 7;
    localparam int DUP_N    = 11;
    localparam int HALF_N   = PERIPH_N / 2;

    typedef enum logic [3:0] {
        RS_SUMMARY, RS_PEND_LO, RS_PEND_HI, RS_FAST_CTL,
        RS_SET_LO, RS_SET_HI, RS_SET_CORE,
        RS_CLR_LO, RS_CLR_HI, RS_CLR_CORE,
        RS_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [PERIPH_N-1:0] pmask;
        logic [CORE_N-1:0]   cmask;
        logic                fast_en;
        logic [SEL_W-1:0]    fast_sel;
    } ctl_t;

    function automatic reg_sel_e decode_offset(input logic [8:0] off);
        reg_sel_e s;
        case (off)
            9'h000:  s = RS_SUMMARY;
            9'h004:  s = RS_PEND_LO;
            9'h008:  s = RS_PEND_HI;
            9'h00C:  s = RS_FAST_CTL;
            9'h010:  s = RS_SET_LO;
            9'h014:  s = RS_SET_HI;
            9'h018:  s = RS_SET_CORE;
            9'h01C:  s = RS_CLR_LO;
            9'h020:  s = RS_CLR_HI;
            9'h024:  s = RS_CLR_CORE;
            default: s = RS_NONE;
        endcase
        return s;
    endfunction

    // Peripheral line copied into summary bit 10+k.
    function automatic int unsigned mirror_line(input int unsigned k);
        case (k)
            0:  return 7;
            1:  return 9;
            2:  return 10;
            3:  return 18;
            4:  return 19;
            5:  return 53;
            6:  return 54;
            7:  return 55;
            8:  return 56;
            9:  return 57;
            10: return 62;
            default: return 0;
        endcase
    endfunction

    // Raw level of the line chosen by the fast-interrupt index.
    function automatic logic fast_pick(input logic [PERIPH_N-1:0] p,
                                       input logic [CORE_N-1:0] c,
                                       input logic [SEL_W-1:0] sel);
        if (!sel[6])
            return p[sel[5:0]];
        else if (sel[5:3] == 3'b000)
            return c[sel[2:0]];
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/lvl_irq_ctl.sv
module lvl_irq_ctl
    import lvl_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl_q,
    output ctl_t              ctl_d
);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            case (sel)
                RS_FAST_CTL: begin
                    ctl_d.fast_sel = wdata[SEL_W-1:0];
                    ctl_d.fast_en  = wdata[SEL_W];
                end
                RS_SET_LO:   ctl_d.pmask[HALF_N-1:0]        = ctl_q.pmask[HALF_N-1:0] | wdata;
                RS_SET_HI:   ctl_d.pmask[PERIPH_N-1:HALF_N] = ctl_q.pmask[PERIPH_N-1:HALF_N] | wdata;
                RS_SET_CORE: ctl_d.cmask                    = ctl_q.cmask | wdata[CORE_N-1:0];
                RS_CLR_LO:   ctl_d.pmask[HALF_N-1:0]        = ctl_q.pmask[HALF_N-1:0] & ~wdata;
                RS_CLR_HI:   ctl_d.pmask[PERIPH_N-1:HALF_N] = ctl_q.pmask[PERIPH_N-1:HALF_N] & ~wdata;
                RS_CLR_CORE: ctl_d.cmask                    = ctl_q.cmask & ~wdata[CORE_N-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    p_set_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RS_SET_LO) |=>
        ((ctl_q.pmask[HALF_N-1:0] & $past(wdata)) == $past(wdata)));

    p_clr_removes_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RS_CLR_HI) |=>
        ((ctl_q.pmask[PERIPH_N-1:HALF_N] & $past(wdata)) == '0));

    p_ro_write_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == RS_NONE || sel == RS_PEND_LO || sel == RS_SUMMARY)) |=>
        $stable(ctl_q));

endmodule

// File: rtl/lvl_irq_out.sv
module lvl_irq_out
    import lvl_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIPH_N-1:0] periph,
    input  logic [CORE_N-1:0]   core,
    input  ctl_t                ctl_d,
    output logic                irq_q,
    output logic                fast_q
);

    logic irq_n;
    logic fast_n;

    always_comb begin
        irq_n  = (|(periph & ctl_d.pmask)) || (|(core & ctl_d.cmask));
        fast_n = ctl_d.fast_en && fast_pick(periph, core, ctl_d.fast_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            fast_q <= 1'b0;
        end else begin
            irq_q  <= irq_n;
            fast_q <= fast_n;
        end
    end

    p_irq_unmasked_low_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl_d.pmask == '0 && ctl_d.cmask == '0) |=> !irq_q);

    p_fast_off_r8: assert property (@(posedge clk) disable iff (rst)
        !ctl_d.fast_en |=> !fast_q);

    p_fast_dead_index_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_d.fast_sel >= 7'd72) |=> !fast_q);

endmodule

// File: rtl/lvl_irq_rd.sv
module lvl_irq_rd
    import lvl_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  reg_sel_e            sel,
    input  logic [PERIPH_N-1:0] periph,
    input  logic [CORE_N-1:0]   core,
    input  ctl_t                ctl_q,
    output logic [DATA_W-1:0]   rd_q
);

    logic [PERIPH_N-1:0] pend;
    logic [CORE_N-1:0]   cpend;
    logic [DUP_N-1:0]    mirror;
    logic [DATA_W-1:0]   summary;
    logic [DATA_W-1:0]   rd_n;

    assign pend  = periph & ctl_q.pmask;
    assign cpend = core & ctl_q.cmask;

    for (genvar k = 0; k < DUP_N; k++) begin : g_mirror
        localparam int unsigned LINE = mirror_line(k);
        assign mirror[k] = pend[LINE];
    end

    assign summary = {{(DATA_W-DUP_N-2-CORE_N){1'b0}}, mirror,
                      |pend[PERIPH_N-1:HALF_N], |pend[HALF_N-1:0], cpend};

    always_comb begin
        case (sel)
            RS_SUMMARY:  rd_n = summary;
            RS_PEND_LO:  rd_n = pend[HALF_N-1:0];
            RS_PEND_HI:  rd_n = pend[PERIPH_N-1:HALF_N];
            RS_FAST_CTL: rd_n = {{(DATA_W-SEL_W-1){1'b0}}, ctl_q.fast_en, ctl_q.fast_sel};
            RS_SET_LO:   rd_n = ctl_q.pmask[HALF_N-1:0];
            RS_SET_HI:   rd_n = ctl_q.pmask[PERIPH_N-1:HALF_N];
            RS_SET_CORE: rd_n = {{(DATA_W-CORE_N){1'b0}}, ctl_q.cmask};
            RS_CLR_LO:   rd_n = ~ctl_q.pmask[HALF_N-1:0];
            RS_CLR_HI:   rd_n = ~ctl_q.pmask[PERIPH_N-1:HALF_N];
            RS_CLR_CORE: rd_n = ~{{(DATA_W-CORE_N){1'b0}}, ctl_q.cmask};
            default:     rd_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= rd_n;
    end

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == RS_NONE) |=> (rd_q == '0));

    p_rd_holds_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));

endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
    import lvl_irq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIPH_N-1:0] periph_lvl,
    input  logic [CORE_N-1:0]   core_lvl,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq,
    output logic                fiq
);

    localparam int OFF_W = 9;

    logic [OFF_W-1:0] off;
    reg_sel_e         sel;
    logic             wr_en;
    logic             rd_en;
    ctl_t             ctl_q;
    ctl_t             ctl_d;

    if (ADDR_W > OFF_W) begin : g_wide
        logic hi_zero;
        assign hi_zero = (req_addr[ADDR_W-1:OFF_W] == '0);
        assign off     = req_addr[OFF_W-1:0];
        assign sel     = hi_zero ? decode_offset(off) : RS_NONE;
    end else begin : g_narrow
        assign off = OFF_W'(req_addr);
        assign sel = decode_offset(off);
    end

    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;

    lvl_irq_ctl u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (req_wdata),
        .ctl_q (ctl_q),
        .ctl_d (ctl_d)
    );

    lvl_irq_out u_out (
        .clk    (clk),
        .rst    (rst),
        .periph (periph_lvl),
        .core   (core_lvl),
        .ctl_d  (ctl_d),
        .irq_q  (irq),
        .fast_q (fiq)
    );

    lvl_irq_rd u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .sel    (sel),
        .periph (periph_lvl),
        .core   (core_lvl),
        .ctl_q  (ctl_q),
        .rd_q   (rd_data)
    );

endmodule

// File: tb/test_lvl_irq_agg.sv
module test_lvl_irq_agg;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] periph_lvl;
    logic [7:0]  core_lvl;
    logic        req_valid;
    logic        req_write;
    logic [8:0]  req_addr;
    logic [31:0] req_wdata;
    logic [31:0] rd_data;
    logic        irq;
    logic        fiq;

    always #4 clk = ~clk;

    lvl_irq_agg i_lvl_irq_agg (
        .clk(clk), .rst(rst), .periph_lvl(periph_lvl), .core_lvl(core_lvl),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .irq(irq), .fiq(fiq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of software-visible state
    logic [63:0] m_pm;
    logic [7:0]  m_cm;
    logic        m_fen;
    logic [6:0]  m_fsel;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    int mirror_list[11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [8:0] a);
        logic [63:0] p = periph_lvl & m_pm;
        logic [31:0] r = '0;
        case (a)
            9'h000: begin
                r[7:0] = core_lvl & m_cm;
                r[8]   = |p[31:0];
                r[9]   = |p[63:32];
                for (int k = 0; k < 11; k++) r[10+k] = p[mirror_list[k]];
            end
            9'h004: r = p[31:0];
            9'h008: r = p[63:32];
            9'h00C: r = {24'h0, m_fen, m_fsel};
            9'h010: r = m_pm[31:0];
            9'h014: r = m_pm[63:32];
            9'h018: r = {24'h0, m_cm};
            9'h01C: r = ~m_pm[31:0];
            9'h020: r = ~m_pm[63:32];
            9'h024: r = ~{24'h0, m_cm};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic model_irq();
        return (|(periph_lvl & m_pm)) || (|(core_lvl & m_cm));
    endfunction

    function automatic logic model_fiq();
        if (!m_fen) return 1'b0;
        if (m_fsel < 64) return periph_lvl[m_fsel];
        if (m_fsel < 72) return core_lvl[m_fsel - 64];
        return 1'b0;
    endfunction

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk);
        case (a)
            9'h00C: begin m_fsel = d[6:0]; m_fen = d[7]; end
            9'h010: m_pm[31:0]  = m_pm[31:0] | d;
            9'h014: m_pm[63:32] = m_pm[63:32] | d;
            9'h018: m_cm        = m_cm | d[7:0];
            9'h01C: m_pm[31:0]  = m_pm[31:0] & ~d;
            9'h020: m_pm[63:32] = m_pm[63:32] & ~d;
            9'h024: m_cm        = m_cm & ~d[7:0];
            default: ;
        endcase
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [8:0] a, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 0;
    endtask

    // outputs after the next edge against the model (R10 timing)
    task automatic chk_out(input string tag);
        logic ei, ef;
        @(posedge clk);
        ei = model_irq();
        ef = model_fiq();
        #2;
        check({tag, " irq"}, {31'h0, irq}, {31'h0, ei});
        check({tag, " fiq"}, {31'h0, fiq}, {31'h0, ef});
    endtask

    task automatic set_lvl(input logic [63:0] p, input logic [7:0] c);
        @(negedge clk);
        periph_lvl = p; core_lvl = c;
    endtask

    // monitor: read data appears one edge after the request (R10)
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && req_valid && !req_write) begin
                #2;
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        periph_lvl = '1; core_lvl = '1;
        m_pm = '0; m_cm = '0; m_fen = 0; m_fsel = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
        check("R1 fiq after reset", {31'h0, fiq}, 32'h0);
        check("R1 rd_data after reset", rd_data, 32'h0);
        @(negedge clk); rst = 0;
        rd(9'h010, "R1 low mask clear");
        rd(9'h018, "R1 core mask clear");
        rd(9'h00C, "R1 fast control clear");
        chk_out("R1 outputs with masks clear");

        // R2 set and accumulate
        set_lvl('0, '0);
        wr(9'h010, 32'h0000_0481);
        wr(9'h010, 32'h8000_0100);
        rd(9'h010, "R2 low set accumulate");
        wr(9'h014, 32'h4000_0021);
        rd(9'h014, "R2 high set");
        wr(9'h018, 32'hFFFF_FF05);
        rd(9'h018, "R2 core set upper ignored");
        rd(9'h024, "R4 core inverse");
        rd(9'h01C, "R4 low inverse");

        // R3 clear
        wr(9'h01C, 32'h0000_0401);
        rd(9'h010, "R3 low clear");
        wr(9'h020, 32'h0000_0001);
        rd(9'h020, "R3 R4 high clear inverse");
        wr(9'h024, 32'h0000_0004);
        rd(9'h018, "R3 core clear");

        // R9 / R10: enable then level, output on the next edge
        wr(9'h01C, 32'hFFFF_FFFF); wr(9'h020, 32'hFFFF_FFFF); wr(9'h024, 32'hFF);
        set_lvl(64'h0000_0000_0000_0040, 8'h00);
        chk_out("R9 active but masked");
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 9'h010; req_wdata = 32'h40;
        @(posedge clk); m_pm[6] = 1'b1; #2;
        check("R10 irq one edge after write", {31'h0, irq}, 32'h1);
        @(negedge clk); req_valid = 0;
        set_lvl('0, '0);
        chk_out("R10 R9 level drop");

        // R5 R6 R9 random patterns
        for (int i = 0; i < 40; i++) begin
            wr(9'h01C, 32'hFFFF_FFFF); wr(9'h020, 32'hFFFF_FFFF); wr(9'h024, 32'hFF);
            wr(9'h010, $urandom); wr(9'h014, $urandom); wr(9'h018, $urandom);
            set_lvl({$urandom, $urandom} & {$urandom, $urandom}, 8'($urandom));
            rd(9'h004, "R5 pending low");
            rd(9'h008, "R5 pending high");
            rd(9'h000, "R6 summary random");
            chk_out("R9 random aggregate");
        end

        // R6 mirror lines, one at a time, full masks
        wr(9'h010, 32'hFFFF_FFFF); wr(9'h014, 32'hFFFF_FFFF); wr(9'h018, 32'hFF);
        for (int l = 0; l < 64; l++) begin
            set_lvl(64'h1 << l, 8'h00);
            rd(9'h000, "R6 single line summary");
        end
        set_lvl(64'h0, 8'h81);
        rd(9'h000, "R6 core bits only");

        // R7 R8 fast interrupt with masks cleared
        wr(9'h01C, 32'hFFFF_FFFF); wr(9'h020, 32'hFFFF_FFFF); wr(9'h024, 32'hFF);
        wr(9'h00C, 32'hFFFF_FF85);
        rd(9'h00C, "R7 fast control readback");
        set_lvl(64'h20, 8'h00);
        chk_out("R8 peripheral source ignores mask");
        for (int s = 0; s < 128; s += 3) begin
            wr(9'h00C, 32'h80 | s);
            set_lvl({$urandom, $urandom}, 8'($urandom));
            chk_out("R8 index sweep");
            set_lvl('1, '1);
            chk_out("R8 index sweep all high");
        end
        wr(9'h00C, 32'h80 | 66);
        set_lvl('0, 8'h04);
        chk_out("R8 core index 66");
        wr(9'h00C, 32'h80 | 72);
        set_lvl('1, '1);
        chk_out("R8 dead index 72");
        wr(9'h00C, 32'h0000_0005);
        chk_out("R8 disabled low");
        rd(9'h00C, "R7 enable cleared readback");

        // R11 unmapped and read-only
        wr(9'h010, 32'h0000_00F0);
        rd(9'h028, "R11 unmapped read");
        rd(9'h011, "R11 unaligned read");
        rd(9'h1FC, "R11 top offset read");
        wr(9'h004, 32'hFFFF_FFFF);
        wr(9'h000, 32'hFFFF_FFFF);
        wr(9'h030, 32'hFFFF_FFFF);
        wr(9'h012, 32'hFFFF_FFFF);
        rd(9'h010, "R11 low mask untouched");
        rd(9'h014, "R11 high mask untouched");
        rd(9'h00C, "R11 fast control untouched");

        repeat (4) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule